// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the timing strobes that a UART transmitter and receiver run on. Each bit is cut into sixteen sub-bit periods. Every sub-bit period lasts a base number of source clocks set by an integer divisor. A 16-bit slot map lengthens chosen sub-bit periods by one clock, which spreads the fractional part of the ideal divide ratio across the bit. A single-cycle sample tick marks the end of every sub-bit period, and a bit tick marks every sixteenth one.

The block lives in one synchronous clock domain. The source-clock choice is made through clock-enable strobes: the peripheral clock advances on every cycle, and the external clock and the PLL clock each advance only on cycles where their strobe is high. Software works out the divisor and the slot map. A ratio of source clock to sixteen times the baud rate of Q gives a divisor of trunc(Q) − 1. The fraction of Q, times sixteen and truncated, picks a map with that many set bits. The block loads both values and holds them fixed for a whole bit, so a change never produces a shortened bit.

Top module: `frac_baud_gen`

## Requirements
- R1: `sample_tick` is a single-cycle pulse at the end of each sub-bit period. A period whose slot bit is clear lasts `divisor`+1 advancing clocks, so `divisor` = 0 gives a tick on every advancing clock.
- R2: Sub-bit period k (0 to 15) lasts one extra advancing clock when bit k of `slot_map` is set. Period 0 is the first period after enable rises or after a bit tick.
- R3: `bit_tick` is high together with every sixteenth `sample_tick`, at the end of sub-bit period 15, and at no other time.
- R4: The `src_sel` codes work as follows. Code 0 and code 2 both select the peripheral clock, so every clock advances. Code 1 advances only on clocks with `ext_clk_en` high, and code 3 advances only on clocks with `pll_clk_en` high. A clock that does not advance never carries a tick.
- R5: While enabled, new values on `divisor` or `slot_map` take effect from the first sub-bit period after the next bit tick. The rest of the current bit keeps the old values.
- R6: While `enable` is low, neither tick is produced and the counters return to zero. When `enable` rises, timing restarts at sub-bit period 0 with the values present on the inputs in that first cycle.
- R7: While `rst_n` is low, both ticks stay low whatever the other inputs are.
- R8: One bit lasts 16×(`divisor`+1) + popcount(`slot_map`) advancing clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| enable | input | 1 | Runs the generator; low clears the counters |
| src_sel | input | 2 | Source-clock select: 0 and 2 peripheral, 1 external, 3 PLL |
| ext_clk_en | input | 1 | Enable strobe of the external source clock |
| pll_clk_en | input | 1 | Enable strobe of the PLL source clock |
| divisor | input | DIV_W | Base sub-bit period length minus one |
| slot_map | input | 16 | Per-sub-bit extra-clock bitmap, bit k for period k |
| sample_tick | output | 1 | End of a sub-bit period (16x oversampling strobe) |
| bit_tick | output | 1 | End of a bit, coincides with a sample tick |

## Verification
The assertions take these things for granted about the inputs:
- The strobes, the source select and the enable are synchronous to `clk` and are sampled once per cycle.
- `divisor`+1 fits the period counter, which is one bit wider than the divisor for that reason.

Under these assumptions, the period counter never passes its limit, and the tick counts over a bit always equal the R8 formula. The stimulus meets these assumptions in the following ways:
- It changes every input just after a falling edge.
- It drops `enable` between scenarios.
- It places divisor and slot-map changes in the middle of a bit, so that the bit-boundary rule can be observed on the ticks.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Source-clock select codes; two codes map to the peripheral clock.
  typedef enum logic [1:0] {
    SRC_PERIPH     = 2'd0,
    SRC_EXTERNAL   = 2'd1,
    SRC_PERIPH_ALT = 2'd2,
    SRC_PLL        = 2'd3
  } clk_src_e;

  localparam int SUB_BITS_DEFAULT = 16;

endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
  import baud_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       ext_clk_en,
  input  logic       pll_clk_en,
  output logic       src_tick
);

  clk_src_e src;

  always_comb begin
    src = clk_src_e'(src_sel);
    unique case (src)
      SRC_PERIPH,
      SRC_PERIPH_ALT: src_tick = 1'b1;
      SRC_EXTERNAL:   src_tick = ext_clk_en;
      SRC_PLL:        src_tick = pll_clk_en;
      default:        src_tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/baud_shadow.sv
module baud_shadow #(
  parameter int DIV_W = 16,
  parameter int SLOTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic [SLOTS-1:0] slot_in,
  output logic [DIV_W-1:0] div_q,
  output logic [SLOTS-1:0] slot_q
);

  // Holding copies of the divisor and slot map used for the running bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
    end else if (load) begin
      div_q  <= div_in;
      slot_q <= slot_in;
    end
  end

endmodule

// File: rtl/baud_subcnt.sv
module baud_subcnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             period_end
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit   = (cnt_q == limit);
  assign period_end = run && adv && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (at_limit) cnt_q <= '0;
      else          cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= limit); // R1

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt_q == '0); // R6

endmodule

// File: rtl/baud_phase.sv
module baud_phase #(
  parameter int SLOTS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     step,
  output logic [$clog2(SLOTS)-1:0] phase,
  output logic                     last
);

  localparam int PH_W = $clog2(SLOTS);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOTS - 1);

  logic [PH_W-1:0] phase_q;

  assign phase = phase_q;
  assign last  = (phase_q == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run) begin
      phase_q <= '0;
    end else if (step) begin
      phase_q <= last ? '0 : phase_q + PH_W'(1);
    end
  end

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> phase == (($past(phase) == LAST_PH) ? '0 : $past(phase) + PH_W'(1))); // R3

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SLOTS = SUB_BITS_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       src_sel,
  input  logic             ext_clk_en,
  input  logic             pll_clk_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [SLOTS-1:0] slot_map,
  output logic             sample_tick,
  output logic             bit_tick
);

  localparam int PH_W   = $clog2(SLOTS);
  localparam int CNT_W  = DIV_W + 1;
  localparam int BITC_W = DIV_W + PH_W + 2;

  // Length of one sub-bit period, in advancing clocks, minus one.
  function automatic logic [CNT_W-1:0] period_limit(
    input logic [DIV_W-1:0] d,
    input logic [SLOTS-1:0] s,
    input logic [PH_W-1:0]  p
  );
    return {1'b0, d} + CNT_W'(s[p]);
  endfunction

  // Advancing clocks in one whole bit.
  function automatic logic [BITC_W-1:0] bit_clocks(
    input logic [DIV_W-1:0] d,
    input logic [SLOTS-1:0] s
  );
    return BITC_W'(SLOTS) * (BITC_W'(d) + BITC_W'(1)) + BITC_W'($countones(s));
  endfunction

  // Named internal events
  logic             run;
  logic             src_tick;
  logic             active_q;
  logic             load;
  logic [DIV_W-1:0] div_q;
  logic [SLOTS-1:0] slot_q;
  logic [DIV_W-1:0] div_use;
  logic [SLOTS-1:0] slot_use;
  logic [PH_W-1:0]  phase;
  logic             last_phase;
  logic [CNT_W-1:0] limit;
  logic             period_end;

  assign run = enable && rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= enable;
  end

  // First enabled cycle runs on the live inputs; afterwards on the held copy.
  assign div_use  = active_q ? div_q  : divisor;
  assign slot_use = active_q ? slot_q : slot_map;
  assign load     = !active_q || bit_tick;

  baud_src_sel u_src (
    .src_sel    (src_sel),
    .ext_clk_en (ext_clk_en),
    .pll_clk_en (pll_clk_en),
    .src_tick   (src_tick)
  );

  baud_shadow #(.DIV_W(DIV_W), .SLOTS(SLOTS)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .div_in  (divisor),
    .slot_in (slot_map),
    .div_q   (div_q),
    .slot_q  (slot_q)
  );

  assign limit = period_limit(div_use, slot_use, phase);

  baud_subcnt #(.CNT_W(CNT_W)) u_subcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .adv        (src_tick),
    .limit      (limit),
    .period_end (period_end)
  );

  baud_phase #(.SLOTS(SLOTS)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .step  (period_end),
    .phase (phase),
    .last  (last_phase)
  );

  assign sample_tick = period_end;
  assign bit_tick    = period_end && last_phase;

  // Advancing clocks seen so far in the running bit.
  logic [BITC_W-1:0] bit_adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              bit_adv_q <= '0;
    else if (!run)           bit_adv_q <= '0;
    else if (bit_tick)       bit_adv_q <= '0;
    else if (src_tick)       bit_adv_q <= bit_adv_q + BITC_W'(1);
  end

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R3

  AST_NO_TICK_WITHOUT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |-> !sample_tick); // R4

  AST_HELD_WITHIN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && $past(active_q) && !$past(bit_tick) |-> $stable(div_use) && $stable(slot_use)); // R5

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !sample_tick && !bit_tick); // R6

  AST_BIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (bit_adv_q + BITC_W'(1)) == bit_clocks(div_use, slot_use)); // R8

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!sample_tick && !bit_tick); // R7
  end

endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [1:0]  src_sel;
  logic        ext_clk_en;
  logic        pll_clk_en;
  logic [15:0] divisor;
  logic [15:0] slot_map;
  logic        sample_tick;
  logic        bit_tick;

  always #4 clk = ~clk;  // 125 MHz

  frac_baud_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .src_sel     (src_sel),
    .ext_clk_en  (ext_clk_en),
    .pll_clk_en  (pll_clk_en),
    .divisor     (divisor),
    .slot_map    (slot_map),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  int vectors = 0;
  int misses  = 0;
  int step_no = 0;
  int gap_ctr = 0;
  int last_gap = 0;

  // Values applied at the next falling edge
  logic        nx_en;
  logic [1:0]  nx_src;
  logic [15:0] nx_div;
  logic [15:0] nx_slot;

  // Behavioural expectation: remaining clocks in the current sub-bit period
  bit          m_fresh = 1'b1;
  int          m_rem;
  int          m_phase;
  int          m_div;
  logic [15:0] m_slot;

  task automatic check_bit(input logic got, input logic exp, input string tag, input string what);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s %s at step %0d: actual %0b expected %0b", tag, what, step_no, got, exp);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag, input string what);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic run_steps(input int n, input int ext_mod, input int pll_mod, input string tag);
    for (int i = 0; i < n; i++) begin
      logic adv, exp_s, exp_b;
      @(negedge clk);
      enable     = nx_en;
      src_sel    = nx_src;
      divisor    = nx_div;
      slot_map   = nx_slot;
      ext_clk_en = ((step_no % ext_mod) == 0);
      pll_clk_en = ((step_no % pll_mod) == 0);
      step_no++;
      #1;
      case (nx_src)
        2'd1:    adv = ext_clk_en;
        2'd3:    adv = pll_clk_en;
        default: adv = 1'b1;
      endcase
      exp_s = 1'b0;
      exp_b = 1'b0;
      if (!nx_en) begin
        m_fresh = 1'b1;
      end else begin
        if (m_fresh) begin
          m_fresh = 1'b0;
          m_div   = int'(nx_div);
          m_slot  = nx_slot;
          m_phase = 0;
          m_rem   = m_div + 1 + int'(m_slot[0]);
          gap_ctr = 0;
        end
        gap_ctr++;
        if (adv) begin
          m_rem--;
          if (m_rem == 0) begin
            exp_s = 1'b1;
            if (m_phase == 15) begin
              exp_b    = 1'b1;
              last_gap = gap_ctr;
              gap_ctr  = 0;
              m_div    = int'(nx_div);
              m_slot   = nx_slot;
            end
            m_phase = (m_phase + 1) % 16;
            m_rem   = m_div + 1 + int'(m_slot[m_phase]);
          end
        end
      end
      check_bit(sample_tick, exp_s, tag, "sample_tick");
      check_bit(bit_tick, exp_b, tag, "bit_tick");
    end
  endtask

  task automatic idle(input int n);
    nx_en = 1'b0;
    run_steps(n, 1, 1, "R6");
  endtask

  // R7: reset keeps both ticks low even with a one-clock period configured
  task automatic t_reset;
    rst_n = 1'b0; enable = 1'b1; src_sel = 2'd0; divisor = 16'd0; slot_map = 16'd0;
    ext_clk_en = 1'b0; pll_clk_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check_bit(sample_tick, 1'b0, "R7", "sample_tick in reset");
      check_bit(bit_tick, 1'b0, "R7", "bit_tick in reset");
    end
    @(negedge clk);
    enable = 1'b0;
    nx_en = 1'b0; nx_src = 2'd0; nx_div = 16'd0; nx_slot = 16'd0;
    rst_n = 1'b1;
  endtask

  // R1 / R3: plain integer division, then divisor zero
  task automatic t_integer;
    idle(2);
    nx_en = 1'b1; nx_div = 16'd3; nx_slot = 16'h0000; nx_src = 2'd0;
    run_steps(140, 1, 1, "R1");
    check_int(last_gap, 64, "R3", "clocks per bit, divisor 3");
    idle(2);
    nx_en = 1'b1; nx_div = 16'd0;
    run_steps(40, 1, 1, "R1");
    check_int(last_gap, 16, "R3", "clocks per bit, divisor 0");
  endtask

  // R2: extra clocks in the sub-bit periods picked by the slot map
  task automatic t_slots;
    logic [15:0] maps [3] = '{16'h0080, 16'h4A52, 16'hFFDF};
    for (int k = 0; k < 3; k++) begin
      idle(2);
      nx_en = 1'b1; nx_div = 16'd2; nx_slot = maps[k]; nx_src = 2'd0;
      run_steps(130, 1, 1, "R2");
    end
  endtask

  // R8: whole-bit length
  task automatic t_bitlen;
    idle(2);
    nx_en = 1'b1; nx_div = 16'd4; nx_slot = 16'hD555; nx_src = 2'd0;
    run_steps(200, 1, 1, "R8");
    check_int(last_gap, 89, "R8", "clocks per bit, divisor 4 map D555");
  endtask

  // R4: source selection through the enable strobes
  task automatic t_source;
    idle(2);
    nx_en = 1'b1; nx_div = 16'd1; nx_slot = 16'h0808; nx_src = 2'd1;
    run_steps(150, 3, 2, "R4");
    nx_src = 2'd3;
    run_steps(150, 3, 2, "R4");
    nx_src = 2'd2;
    run_steps(80, 3, 2, "R4");
    idle(2);
    nx_en = 1'b1; nx_src = 2'd3; nx_slot = 16'h0000;
    run_steps(200, 3, 5, "R4");
    check_int(last_gap, 160, "R4", "clocks per bit on PLL strobe every 5th clock");
  endtask

  // R5: mid-bit change waits for the next bit boundary
  task automatic t_update;
    idle(2);
    nx_en = 1'b1; nx_div = 16'd2; nx_slot = 16'h0000; nx_src = 2'd0;
    run_steps(20, 1, 1, "R5");
    nx_div = 16'd5; nx_slot = 16'h5555;
    run_steps(200, 1, 1, "R5");
    check_int(last_gap, 104, "R5", "clocks per bit after update");
  endtask

  // R6: disable mid-bit, silence, restart from period 0
  task automatic t_disable;
    idle(2);
    nx_en = 1'b1; nx_div = 16'd3; nx_slot = 16'h0000; nx_src = 2'd0;
    run_steps(30, 1, 1, "R6");
    nx_en = 1'b0;
    run_steps(20, 1, 1, "R6");
    nx_en = 1'b1; nx_slot = 16'h2222;
    run_steps(100, 1, 1, "R6");
    check_int(last_gap, 68, "R6", "first bit after re-enable");
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_integer();
    t_slots();
    t_bitlen();
    t_source();
    t_update();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule